// File: doc/BRIEF.md
# Reply Path Latency Budget Monitor

This block watches the timing of a transponder reply pipeline while it runs. Five single-cycle marker inputs report, in order, pulse detection, request acceptance, scheduler dequeue, encoder start and the PA power-detect edge. A free-running cycle counter provides the common time reference. The detection marker opens a transaction and stamps it. Each later marker closes one of four segments. The block measures each segment in clock cycles and compares it with a per-segment limit that software sets.

A segment that runs longer than its limit becomes a violation record. The record holds the stage index, the measured latency, the timestamp, and the lock and protect state sampled in that cycle. Records wait in a small show-ahead queue for readout. For every segment the block keeps a minimum, a maximum, a saturating sum and a saturating count, so a mean can be formed later. Markers that arrive out of order, or that arrive while no transaction is open, abort the transaction and increment a saturating error counter. A transaction that stalls past a programmable total limit is closed with a timeout record.

Top module: `latency_budget_monitor`

## Requirements
- R1: The timebase is reset to zero and advances by one each cycle. The latency of a segment is the number of cycles between the edge that samples its opening marker and the edge that samples its closing marker. Statistics slot k (0 to 3) belongs to the segment that closes at marker bit k+1.
- R2: Marker bit 0 is detection, bit 1 is request accepted, bit 2 is scheduler dequeue, bit 3 is encoder start and bit 4 is PA power edge. While idle, a marker word equal to 5'b00001 opens a transaction. A transaction then expects bits 1, 2, 3 and 4 one at a time, in that order. After bit 4 the block returns to idle.
- R3: A completed segment whose latency is strictly greater than its limit (`seg_budget[k*TW +: TW]`) produces a violation record. A latency equal to the limit produces no record.
- R4: A budget record carries stage = k+1, timeout flag 0, the measured latency, the timebase value when the closing marker was sampled, and `lock_ok` and `protect_on` as sampled in that cycle.
- R5: Records enter a queue of FDEPTH entries. The queue presents its oldest entry with `rec_valid` high and removes it on `rec_pop`. A record produced while the queue is full is discarded, and the stored entries stay unchanged.
- R6: Each segment completion updates that slot's minimum, maximum, sum and count one cycle later. Timeout and abort events leave the statistics unchanged.
- R7: The sum and the count saturate at their all-ones values instead of wrapping.
- R8: Any of the following counts as one sequencing error: a nonzero marker word other than the expected single bit while a transaction is open, including a repeated detection; or a marker word other than 5'b00001 while idle. The open transaction is dropped without a record and without a statistics update.
- R9: If no marker arrives in the cycle when the time since detection reaches `total_limit`, the transaction closes with a record. That record holds stage = the index of the marker still awaited, timeout flag 1, the time since the last marker as latency, and the current timebase as stamp.
- R10: After reset the queue is empty, the error counter is zero, every count and sum is zero, every minimum is all ones and every maximum is zero.
- R11: The sequencing error counter saturates at its all-ones value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| stage_mark | input | 5 | Stage marker pulses, bit 0 detection to bit 4 PA power edge |
| seg_budget | input | 4*TW | Latency limit per segment, slot k in bits k*TW upward |
| total_limit | input | TW | Maximum cycles from detection to the last marker, at least 1 |
| lock_ok | input | 1 | Synthesizer lock state, captured into records |
| protect_on | input | 1 | Receiver protect state, captured into records |
| rec_valid | output | 1 | Queue holds at least one record |
| rec_pop | input | 1 | Remove the presented record |
| rec_stage | output | 3 | Stage index of the presented record |
| rec_timeout | output | 1 | Record came from the total timeout |
| rec_latency | output | TW | Measured latency of the record |
| rec_stamp | output | TW | Timebase value when the record was produced |
| rec_lock | output | 1 | Lock state captured in the record |
| rec_protect | output | 1 | Protect state captured in the record |
| stat_sel | input | 2 | Segment slot chosen for the statistics outputs |
| stat_min | output | TW | Smallest latency seen in the chosen slot |
| stat_max | output | TW | Largest latency seen in the chosen slot |
| stat_sum | output | SUMW | Saturating latency sum of the chosen slot |
| stat_cnt | output | CNTW | Saturating completion count of the chosen slot |
| seq_errors | output | ERRW | Saturating sequencing error count |

## Verification
The assertions assume that `total_limit` is at least one and does not change while a transaction is open. They also assume that the limit stays below the timebase wrap, so the elapsed time of an open transaction never exceeds it. The stimulus sets the limits once, before reset is released, and leaves them unchanged. Markers are driven one word per cycle between clock edges. The queue is drained only at points where the expected contents are known, so the overflow and empty-pop properties are exercised by the full-queue and drain sequences.

// File: rtl/lbm_pkg.sv
// Shared constants and types for the reply path latency budget monitor.
// Assumes exactly five ordered markers, which give four measured segments.
package lbm_pkg;
    localparam int unsigned NUM_MARKS = 5;
    localparam int unsigned NUM_SEGS  = NUM_MARKS - 1;
    localparam int unsigned SEG_IW    = $clog2(NUM_SEGS);
    localparam logic [NUM_MARKS-1:0] MARK_DETECT = 5'b00001;

    typedef logic [2:0] stage_t;

    typedef enum logic {
        TRK_IDLE = 1'b0,
        TRK_BUSY = 1'b1
    } trk_state_e;
endpackage

// File: rtl/lbm_tracker.sv
// Transaction sequencer. Opens a transaction on a lone detection marker and
// expects the remaining markers one at a time, in order. It reports segment
// completions with their latency, sequencing errors and the total timeout.
// Assumes total_limit >= 1, held constant while a transaction is open.
module lbm_tracker
    import lbm_pkg::*;
#(
    parameter int unsigned TW = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_MARKS-1:0] mark,
    input  logic [TW-1:0]        now,
    input  logic [TW-1:0]        total_limit,
    output logic                 seg_done,
    output logic [SEG_IW-1:0]    seg_idx,
    output logic [TW-1:0]        seg_lat,
    output logic                 tmo_fire,
    output stage_t               tmo_stage,
    output logic                 seq_bad
);
    trk_state_e           state_q;
    stage_t               nxt_q;
    logic [TW-1:0]        seg_t0_q;
    logic [TW-1:0]        det_t0_q;
    logic [NUM_MARKS-1:0] exp_mark;
    logic [TW-1:0]        elapsed;
    logic                 busy, opening, hit, last;

    // Decode the marker word against the expected next marker.
    always_comb begin
        busy      = (state_q == TRK_BUSY);
        exp_mark  = MARK_DETECT << nxt_q;
        opening   = !busy && (mark == MARK_DETECT);
        hit       = busy && (mark == exp_mark);
        last      = (nxt_q == stage_t'(NUM_SEGS));
        elapsed   = now - det_t0_q;
        seg_lat   = now - seg_t0_q;
        tmo_fire  = busy && (mark == '0) && (elapsed >= total_limit);
        seq_bad   = (mark != '0) && !opening && !hit;
        seg_done  = hit;
        seg_idx   = SEG_IW'(nxt_q - 3'd1);
        tmo_stage = nxt_q;
    end

    // Advance the transaction state and hold the segment and detection stamps.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= TRK_IDLE;
            nxt_q    <= 3'd1;
            seg_t0_q <= '0;
            det_t0_q <= '0;
        end else if (opening) begin
            state_q  <= TRK_BUSY;
            nxt_q    <= 3'd1;
            seg_t0_q <= now;
            det_t0_q <= now;
        end else if (hit) begin
            seg_t0_q <= now;
            nxt_q    <= nxt_q + 3'd1;
            if (last) state_q <= TRK_IDLE;
        end else if (busy && (seq_bad || tmo_fire)) begin
            state_q <= TRK_IDLE;
        end
    end

    // An open transaction never outlives the total limit.
    assert_within_total_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (elapsed <= total_limit));
endmodule

// File: rtl/lbm_seg_stats.sv
// Per-segment latency summary: minimum, maximum, saturating sum and
// saturating count, updated on each completed segment.
// Assumes upd is a single-cycle strobe with lat valid in that cycle.
module lbm_seg_stats #(
    parameter int unsigned TW   = 16,
    parameter int unsigned SUMW = 24,
    parameter int unsigned CNTW = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            upd,
    input  logic [TW-1:0]   lat,
    output logic [TW-1:0]   lat_min,
    output logic [TW-1:0]   lat_max,
    output logic [SUMW-1:0] lat_sum,
    output logic [CNTW-1:0] lat_cnt
);
    localparam int unsigned AW = ((SUMW > TW) ? SUMW : TW) + 1;
    localparam logic [SUMW-1:0] SUM_TOP = '1;

    logic [AW-1:0]   acc;
    logic [SUMW-1:0] sum_d;

    // Form the next sum, clamped at the all-ones value.
    always_comb begin
        acc = AW'(lat_sum) + AW'(lat);
        if (acc > AW'(SUM_TOP)) sum_d = SUM_TOP;
        else                    sum_d = acc[SUMW-1:0];
    end

    // Fold each completed latency into the summary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_min <= '1;
            lat_max <= '0;
            lat_sum <= '0;
            lat_cnt <= '0;
        end else if (upd) begin
            if (lat < lat_min) lat_min <= lat;
            if (lat > lat_max) lat_max <= lat;
            lat_sum <= sum_d;
            if (lat_cnt != '1) lat_cnt <= lat_cnt + CNTW'(1);
        end
    end

    assert_min_le_max_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (lat_cnt != '0) |-> (lat_min <= lat_max));
    assert_cnt_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (lat_cnt == '1) |=> (lat_cnt == '1));
    assert_sum_no_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(rst_n) |=> (lat_sum >= $past(lat_sum)));
endmodule

// File: rtl/lbm_rec_fifo.sv
// Show-ahead record queue. A push while full is discarded.
// Assumes DEPTH >= 2.
module lbm_rec_fifo #(
    parameter int unsigned W     = 8,
    parameter int unsigned DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic         empty,
    output logic [W-1:0] head
);
    localparam int unsigned PW = $clog2(DEPTH);
    localparam int unsigned CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem_q [DEPTH];
    logic [PW-1:0] wr_q, rd_q;
    logic [CW-1:0] count_q;
    logic          full, do_push, do_pop;

    // Flags and accepted operations for this cycle.
    always_comb begin
        empty   = (count_q == '0);
        full    = (count_q == CW'(DEPTH));
        do_push = push && !full;
        do_pop  = pop && !empty;
        head    = mem_q[rd_q];
    end

    // Storage, pointers and fill level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q    <= '0;
            rd_q    <= '0;
            count_q <= '0;
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else begin
            if (do_push) begin
                mem_q[wr_q] <= din;
                wr_q <= (wr_q == PW'(DEPTH - 1)) ? '0 : wr_q + PW'(1);
            end
            if (do_pop) rd_q <= (rd_q == PW'(DEPTH - 1)) ? '0 : rd_q + PW'(1);
            if (do_push && !do_pop)      count_q <= count_q + CW'(1);
            else if (do_pop && !do_push) count_q <= count_q - CW'(1);
        end
    end

    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop) |=> (count_q == CW'(DEPTH)));
    assert_no_underflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && pop && !push) |=> (count_q == '0));
endmodule

// File: rtl/latency_budget_monitor.sv
// Reply path latency budget monitor top. Owns the timebase, checks each
// completed segment against its limit, builds violation records, keeps the
// per-segment summaries and counts sequencing errors.
// Assumes the limit inputs are quasi-static and total_limit >= 1.
module latency_budget_monitor
    import lbm_pkg::*;
#(
    parameter int unsigned TW     = 16,
    parameter int unsigned SUMW   = 24,
    parameter int unsigned CNTW   = 12,
    parameter int unsigned ERRW   = 8,
    parameter int unsigned FDEPTH = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_MARKS-1:0] stage_mark,
    input  logic [4*TW-1:0]      seg_budget,
    input  logic [TW-1:0]        total_limit,
    input  logic                 lock_ok,
    input  logic                 protect_on,
    output logic                 rec_valid,
    input  logic                 rec_pop,
    output logic [2:0]           rec_stage,
    output logic                 rec_timeout,
    output logic [TW-1:0]        rec_latency,
    output logic [TW-1:0]        rec_stamp,
    output logic                 rec_lock,
    output logic                 rec_protect,
    input  logic [1:0]           stat_sel,
    output logic [TW-1:0]        stat_min,
    output logic [TW-1:0]        stat_max,
    output logic [SUMW-1:0]      stat_sum,
    output logic [CNTW-1:0]      stat_cnt,
    output logic [ERRW-1:0]      seq_errors
);
    localparam int unsigned RW = 3 + 1 + TW + TW + 2;

    logic [TW-1:0]     now_q;
    logic              seg_done, tmo_fire, seq_bad;
    logic [SEG_IW-1:0] seg_idx;
    logic [TW-1:0]     seg_lat, cur_budget;
    stage_t            tmo_stage, rec_stage_d;
    logic              over_budget, rec_push, rec_empty;
    logic [RW-1:0]     rec_din, rec_head;
    logic [ERRW-1:0]   err_q;

    logic [TW-1:0]   mins [NUM_SEGS];
    logic [TW-1:0]   maxs [NUM_SEGS];
    logic [SUMW-1:0] sums [NUM_SEGS];
    logic [CNTW-1:0] cnts [NUM_SEGS];

    // Free-running timebase shared by every stamp and latency.
    always_ff @(posedge clk) begin
        if (!rst_n) now_q <= '0;
        else        now_q <= now_q + TW'(1);
    end

    lbm_tracker #(.TW(TW)) u_trk (
        .clk(clk), .rst_n(rst_n), .mark(stage_mark), .now(now_q),
        .total_limit(total_limit), .seg_done(seg_done), .seg_idx(seg_idx),
        .seg_lat(seg_lat), .tmo_fire(tmo_fire), .tmo_stage(tmo_stage),
        .seq_bad(seq_bad)
    );

    // Budget comparison and record assembly.
    always_comb begin
        cur_budget  = seg_budget[seg_idx*TW +: TW];
        over_budget = seg_done && (seg_lat > cur_budget);
        rec_push    = over_budget || tmo_fire;
        rec_stage_d = seg_done ? (stage_t'(seg_idx) + 3'd1) : tmo_stage;
        rec_din     = {rec_stage_d, tmo_fire, seg_lat, now_q, lock_ok, protect_on};
    end

    lbm_rec_fifo #(.W(RW), .DEPTH(FDEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(rec_push), .din(rec_din),
        .pop(rec_pop), .empty(rec_empty), .head(rec_head)
    );

    assign rec_valid = !rec_empty;
    assign {rec_stage, rec_timeout, rec_latency, rec_stamp, rec_lock, rec_protect} = rec_head;

    generate
        for (genvar s = 0; s < NUM_SEGS; s++) begin : g_seg
            lbm_seg_stats #(.TW(TW), .SUMW(SUMW), .CNTW(CNTW)) u_stat (
                .clk(clk), .rst_n(rst_n),
                .upd(seg_done && (seg_idx == SEG_IW'(s))), .lat(seg_lat),
                .lat_min(mins[s]), .lat_max(maxs[s]),
                .lat_sum(sums[s]), .lat_cnt(cnts[s])
            );
        end
    endgenerate

    // Summary readout for the selected segment.
    always_comb begin
        stat_min = mins[stat_sel];
        stat_max = maxs[stat_sel];
        stat_sum = sums[stat_sel];
        stat_cnt = cnts[stat_sel];
    end

    // Saturating sequencing error counter.
    always_ff @(posedge clk) begin
        if (!rst_n)                      err_q <= '0;
        else if (seq_bad && err_q != '1) err_q <= err_q + ERRW'(1);
    end
    assign seq_errors = err_q;

    assert_err_no_wrap_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(rst_n) |=> (err_q >= $past(err_q)));
    assert_one_event_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(seg_done && tmo_fire));
endmodule

// File: tb/latency_budget_monitor_test.sv
module latency_budget_monitor_test;
    localparam int CLK_PERIOD = 10;
    localparam int TW = 16, SUMW = 8, CNTW = 4, ERRW = 3, FDEPTH = 4;
    localparam int SUM_TOP = 255, CNT_TOP = 15, ERR_TOP = 7;
    localparam int BUD [4] = '{8, 6, 5, 7};
    localparam int LIMIT = 60;
    // gap1..gap4, lock, protect
    localparam int VEC [8][6] = '{
        '{3, 2, 2, 4, 1, 0},
        '{8, 6, 5, 7, 1, 0},
        '{9, 1, 1, 1, 0, 1},
        '{1, 7, 6, 8, 1, 1},
        '{2, 3, 1, 2, 0, 0},
        '{5, 5, 5, 5, 1, 0},
        '{1, 1, 1, 1, 0, 0},
        '{12, 9, 2, 9, 1, 1}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic [4:0] mark = '0;
    logic [4*TW-1:0] seg_budget;
    logic [TW-1:0] total_limit;
    logic lock_ok = 1'b0, protect_on = 1'b0, rec_pop = 1'b0;
    logic rec_valid, rec_timeout, rec_lock, rec_protect;
    logic [2:0] rec_stage;
    logic [TW-1:0] rec_latency, rec_stamp, stat_min, stat_max;
    logic [1:0] stat_sel = '0;
    logic [SUMW-1:0] stat_sum;
    logic [CNTW-1:0] stat_cnt;
    logic [ERRW-1:0] seq_errors;

    int nchk = 0, nfail = 0, cyc = 0, m_seq = 0, ne = 0;
    int m_min [4], m_max [4], m_sum [4], m_cnt [4];
    int e_stage [FDEPTH], e_tmo [FDEPTH], e_lat [FDEPTH], e_stamp [FDEPTH];
    int e_lock [FDEPTH], e_prot [FDEPTH];
    bit done = 1'b0;

    latency_budget_monitor #(.TW(TW), .SUMW(SUMW), .CNTW(CNTW), .ERRW(ERRW), .FDEPTH(FDEPTH)) uut (
        .clk(clk), .rst_n(rst_n), .stage_mark(mark), .seg_budget(seg_budget),
        .total_limit(total_limit), .lock_ok(lock_ok), .protect_on(protect_on),
        .rec_valid(rec_valid), .rec_pop(rec_pop), .rec_stage(rec_stage),
        .rec_timeout(rec_timeout), .rec_latency(rec_latency), .rec_stamp(rec_stamp),
        .rec_lock(rec_lock), .rec_protect(rec_protect), .stat_sel(stat_sel),
        .stat_min(stat_min), .stat_max(stat_max), .stat_sum(stat_sum),
        .stat_cnt(stat_cnt), .seq_errors(seq_errors)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Independent cycle count mirroring the timebase.
    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    task automatic chk(input string tag, input longint act, input longint exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic step(input logic [4:0] m);
        @(negedge clk);
        mark = m;
    endtask

    task automatic seg_update(input int k, input int lat);
        if (m_cnt[k] < CNT_TOP) m_cnt[k]++;
        m_sum[k] = (m_sum[k] + lat > SUM_TOP) ? SUM_TOP : m_sum[k] + lat;
        if (lat < m_min[k]) m_min[k] = lat;
        if (lat > m_max[k]) m_max[k] = lat;
    endtask

    task automatic expect_rec(input int st, input int tmo, input int lat, input int stamp,
                              input int lk, input int pr);
        if (ne < FDEPTH) begin
            e_stage[ne] = st; e_tmo[ne] = tmo; e_lat[ne] = lat;
            e_stamp[ne] = stamp; e_lock[ne] = lk; e_prot[ne] = pr;
            ne++;
        end
    endtask

    task automatic seq_bump();
        if (m_seq < ERR_TOP) m_seq++;
    endtask

    // R1 R2 R3 R4: one ordered transaction with the given segment gaps.
    task automatic run_txn(input int g0, input int g1, input int g2, input int g3,
                           input int lk, input int pr);
        int g [4];
        g = '{g0, g1, g2, g3};
        lock_ok = lk[0];
        protect_on = pr[0];
        step(5'b00001);
        for (int k = 0; k < 4; k++) begin
            repeat (g[k] - 1) step(5'b00000);
            step(5'(1 << (k + 1)));
            seg_update(k, g[k]);
            if (g[k] > BUD[k]) expect_rec(k + 1, 0, g[k], cyc, lk, pr);
        end
        step(5'b00000);
    endtask

    // R4 R5 R9: drain the queue and compare every record in order.
    task automatic drain_check();
        for (int i = 0; i < ne; i++) begin
            @(negedge clk);
            chk("R5 rec_valid", rec_valid, 1);
            chk("R4 rec_stage", rec_stage, e_stage[i]);
            chk("R9 rec_timeout", rec_timeout, e_tmo[i]);
            chk("R1 rec_latency", rec_latency, e_lat[i]);
            chk("R4 rec_stamp", rec_stamp, e_stamp[i]);
            chk("R4 rec_lock", rec_lock, e_lock[i]);
            chk("R4 rec_protect", rec_protect, e_prot[i]);
            rec_pop = 1'b1;
            @(posedge clk);
            #1 rec_pop = 1'b0;
        end
        @(negedge clk);
        chk("R5 queue empty after drain", rec_valid, 0);
        ne = 0;
    endtask

    task automatic drain_quiet();
        @(negedge clk);
        while (rec_valid) begin
            rec_pop = 1'b1;
            @(posedge clk);
            #1 rec_pop = 1'b0;
            @(negedge clk);
        end
        ne = 0;
    endtask

    // R6 R7: compare every segment summary with the model.
    task automatic check_stats();
        for (int s = 0; s < 4; s++) begin
            @(negedge clk);
            stat_sel = 2'(s);
            #1;
            chk("R6 stat_min", stat_min, m_min[s]);
            chk("R6 stat_max", stat_max, m_max[s]);
            chk("R7 stat_sum", stat_sum, m_sum[s]);
            chk("R7 stat_cnt", stat_cnt, m_cnt[s]);
        end
    endtask

    initial begin
        int c0;
        seg_budget = {16'(BUD[3]), 16'(BUD[2]), 16'(BUD[1]), 16'(BUD[0])};
        total_limit = 16'(LIMIT);
        for (int s = 0; s < 4; s++) begin
            m_min[s] = 65535; m_max[s] = 0; m_sum[s] = 0; m_cnt[s] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk("R10 rec_valid", rec_valid, 0);
        chk("R10 seq_errors", seq_errors, 0);
        check_stats();

        // Vector table walk
        for (int v = 0; v < 8; v++) begin
            run_txn(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4], VEC[v][5]);
            drain_check();
            check_stats();
        end
        chk("R8 no errors on ordered traffic", seq_errors, 0);

        // R8 out-of-order marker aborts, then a stray marker while idle
        step(5'b00001); step(5'b00000); step(5'b01000); step(5'b00000);
        seq_bump();
        chk("R8 out-of-order counted", seq_errors, m_seq);
        step(5'b00010); step(5'b00000);
        seq_bump();
        chk("R8 idle stray counted", seq_errors, m_seq);
        check_stats();
        @(negedge clk);
        chk("R8 abort leaves no record", rec_valid, 0);

        // R8 repeated detection aborts the open transaction
        step(5'b00001); step(5'b00000); step(5'b00001); step(5'b00000);
        seq_bump();
        chk("R8 repeated detect counted", seq_errors, m_seq);
        step(5'b00010); step(5'b00000);
        seq_bump();
        chk("R8 dropped detection not reopened", seq_errors, m_seq);

        // R9 total timeout while waiting for dequeue
        lock_ok = 1'b1; protect_on = 1'b0;
        step(5'b00001);
        c0 = cyc;
        step(5'b00000);
        step(5'b00010);
        seg_update(0, 2);
        repeat (62) step(5'b00000);
        expect_rec(2, 1, LIMIT - 2, c0 + LIMIT, 1, 0);
        drain_check();
        check_stats();
        step(5'b00100); step(5'b00000);
        seq_bump();
        chk("R9 transaction closed by timeout", seq_errors, m_seq);

        // R5 full queue discards the fifth record
        for (int t = 0; t < 5; t++) run_txn(9, 1, 1, 1, t % 2, 1);
        drain_check();

        // R7 saturation of sum and count
        for (int t = 0; t < 12; t++) begin
            run_txn(20, 1, 1, 1, 0, 0);
            drain_quiet();
        end
        check_stats();

        // R11 error counter saturation
        for (int t = 0; t < 5; t++) begin
            step(5'b00010); step(5'b00000);
            seq_bump();
        end
        chk("R11 seq_errors saturated", seq_errors, ERR_TOP);

        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            done = 1'b1;
            nchk++;
            nfail++;
            $display("FAIL watchdog expired act=1 exp=0");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end
endmodule